// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame. A holding buffer takes the character while an active-low load strobe is low. A shift register then sends it, least significant bit first. The frame is a low start bit, 5 to 8 data bits, an optional parity bit and a high stop period. All timing runs from a clock enable that pulses at sixteen times the bit rate, so every bit lasts sixteen enabled cycles.

The buffer and the shifter work independently. A character strobed in while another frame is on the line waits in the buffer. It starts on the same enable pulse that ends the previous stop period, so the two frames leave with no idle time between them. The character format comes from static inputs. It is captured when a character moves into the shifter, so the inputs may change while a frame is in flight. Two flags report whether the buffer and the shifter are empty.

Top module: `sertx_dbuf`

## Requirements
- R1: While `rst_n` is low at a clock edge, `txd`, `hold_empty` and `shift_empty` are all 1 after that edge.
- R2: `din` is captured into the buffer on every clock edge where `load_n` is 0. The edge that first sees `load_n` back at 1 drives `hold_empty` to 0. Changes on `din` after that edge do not alter the queued character.
- R3: With the shifter idle, the buffered character moves into the shifter on the first enabled edge after `hold_empty` falls. From that edge `txd` is 0, `hold_empty` is 1 and `shift_empty` is 0.
- R4: State advances only on edges where `tick16` is 1. Every start, data and parity bit lasts exactly 16 enabled edges.
- R5: The frame is start bit 0, then the data bits starting at `din[0]`, then the parity bit if enabled, then stop level 1.
- R6: `len_code` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Inputs of `din` above the selected length are not sent and do not affect parity.
- R7: With `par_off` at 1, no parity bit is sent. Otherwise the parity bit is the XOR of the sent data bits when `par_even` is 1, and its complement when `par_even` is 0.
- R8: The stop period lasts 16 enabled edges when `stop_long` is 0. When `stop_long` is 1 it lasts 24 edges for 5-bit characters and 32 edges for longer ones.
- R9: A character strobed in during a frame keeps `hold_empty` at 0 until the stop period ends. Its start bit begins on the enabled edge that ends that stop period.
- R10: The format inputs are sampled only when a character enters the shifter. Changing them during a frame does not alter that frame.
- R11: When a stop period ends with the buffer empty, `shift_empty` goes to 1 on that edge and `txd` stays 1 until the next transfer.
- R12: A reset during a frame, with a character queued, ends the frame and discards the queued character. After reset is released, `txd` stays 1 and `shift_empty` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| load_n | input | 1 | Active-low buffer load strobe; the rising edge queues the character |
| din | input | 8 | Character data, right justified |
| len_code | input | 2 | Data length select, 5 plus the code |
| par_off | input | 1 | 1 removes the parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| stop_long | input | 1 | 1 selects the long stop period |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding buffer is free |
| shift_empty | output | 1 | Shifter is idle, no frame on the line |

## Verification
A wrong sub-bit count or a wrong bit counter shows up at `txd` within one bit time. It appears as a level flipping at a mid-bit sample, or as `shift_empty` rising a tick too early or too late at the end of the stop period. A lost handover between buffer and shifter shows up in two ways. `hold_empty` stays low past the tick where the stop period ends, or the next start bit lands one tick late. This is visible on the first queued character. A format register that is not held stable shows up as a wrong parity value or a wrong stop length in the same frame.

// File: rtl/sertx_pkg.sv
// Shared types for the double-buffered serial transmitter.
// Assumes: lengths are coded as an offset from the shortest character.
package sertx_pkg;
    localparam int MIN_LEN = 5;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BITS  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_off;
        logic       par_even;
        logic       stop_long;
    } tx_fmt_t;
endpackage

// File: rtl/sertx_holdbuf.sv
// Holding buffer: captures data while the strobe is low and queues the
// character on the strobe's rising edge. It hands the character to the
// shifter on an enabled edge when the shifter reports it can accept one.
// Assumes: load_n is synchronous to clk.
module sertx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ready_i,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              xfer_o
);
    logic load_q;
    logic rise;

    assign rise   = load_n && !load_q;
    assign xfer_o = tick && hold_full && ready_i;

    // Track the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b1;
        else        load_q <= load_n;
    end

    // Capture data on every edge while the strobe is low.
    always_ff @(posedge clk) begin
        if (!load_n) hold_data <= din;
    end

    // Full flag: a handover clears it, a strobe rise sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_full <= 1'b0;
        else if (xfer_o) hold_full <= 1'b0;
        else if (rise)   hold_full <= 1'b1;
    end

    // R2
    hold_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && $past(load_n)) |-> $stable(hold_data));
endmodule

// File: rtl/sertx_framer.sv
// Framer: masks the character to its programmed length, computes parity and
// builds the payload (data then optional parity). It also reports the payload
// bit count and the stop period in enabled ticks.
// Assumes: purely combinational; the shifter latches its outputs.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 4,
    parameter int STW    = 6
) (
    input  logic [DATA_W-1:0] data,
    input  tx_fmt_t           fmt,
    output logic [DATA_W:0]   payload,
    output logic [CNT_W-1:0]  nbits,
    output logic [STW-1:0]    stop_ticks
);
    localparam logic [STW-1:0] STOP_ONE  = STW'(OVS);
    localparam logic [STW-1:0] STOP_HALF = STW'(OVS + OVS / 2);
    localparam logic [STW-1:0] STOP_TWO  = STW'(2 * OVS);

    logic [CNT_W-1:0]  len_n;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] dmask;
    logic              parity;

    assign len_n = CNT_W'(MIN_LEN) + CNT_W'(fmt.len_code);

    // One keep bit per data position below the programmed length.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_keep
        assign keep[gi] = (CNT_W'(gi) < len_n);
    end

    assign dmask  = data & keep;
    assign parity = (^dmask) ^ ~fmt.par_even;

    // Assemble the payload with parity placed right above the last data bit.
    always_comb begin
        payload = '0;
        payload[DATA_W-1:0] = dmask;
        if (!fmt.par_off) payload[len_n] = parity;
    end

    // Count the payload bits and choose the stop period.
    always_comb begin
        nbits = fmt.par_off ? len_n : len_n + CNT_W'(1);
        if (!fmt.stop_long)           stop_ticks = STOP_ONE;
        else if (len_n == CNT_W'(MIN_LEN)) stop_ticks = STOP_HALF;
        else                          stop_ticks = STOP_TWO;
    end
endmodule

// File: rtl/sertx_shifter.sv
// Shifter: sends start bit, payload LSB first and the stop period, advancing
// on enabled ticks only. It accepts a new character on the tick that ends a
// stop period, so queued frames leave end to end.
// Assumes: xfer is only raised on enabled ticks when ready is high.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 4,
    parameter int STW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             xfer,
    input  logic [DATA_W:0]  payload,
    input  logic [CNT_W-1:0] nbits,
    input  logic [STW-1:0]   stop_ticks,
    output logic             txd,
    output logic             idle,
    output logic             ready
);
    localparam logic [STW-1:0] LAST_SUB = STW'(OVS - 1);

    tx_phase_t        phase;
    logic [STW-1:0]   cnt;
    logic [CNT_W-1:0] left;
    logic [DATA_W:0]  sh;
    logic [STW-1:0]   stop_q;
    logic             stop_end;

    assign stop_end = (phase == PH_STOP) && (cnt == stop_q - STW'(1));
    assign ready    = (phase == PH_IDLE) || stop_end;
    assign idle     = (phase == PH_IDLE);

    // Frame sequencer: load, bit timing, payload shifting and stop period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            txd    <= 1'b1;
            cnt    <= '0;
            left   <= '0;
            sh     <= '0;
            stop_q <= STW'(OVS);
        end else if (tick) begin
            if (xfer) begin
                phase  <= PH_START;
                txd    <= 1'b0;
                cnt    <= '0;
                sh     <= payload;
                left   <= nbits;
                stop_q <= stop_ticks;
            end else begin
                case (phase)
                    PH_START: begin
                        if (cnt == LAST_SUB) begin
                            phase <= PH_BITS;
                            txd   <= sh[0];
                            sh    <= sh >> 1;
                            left  <= left - CNT_W'(1);
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + STW'(1);
                        end
                    end
                    PH_BITS: begin
                        if (cnt == LAST_SUB) begin
                            cnt <= '0;
                            if (left == '0) begin
                                phase <= PH_STOP;
                                txd   <= 1'b1;
                            end else begin
                                txd  <= sh[0];
                                sh   <= sh >> 1;
                                left <= left - CNT_W'(1);
                            end
                        end else begin
                            cnt <= cnt + STW'(1);
                        end
                    end
                    PH_STOP: begin
                        if (stop_end) begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + STW'(1);
                        end
                    end
                    default: txd <= 1'b1;
                endcase
            end
        end
    end

    // R11
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> txd);

    // R5
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (!txd && phase == PH_START));

    // R5
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP) |-> txd);

    // R10
    fmt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !xfer) |=> $stable(stop_q));

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(txd)));
endmodule

// File: rtl/sertx_dbuf.sv
// Top of the double-buffered serial transmitter: holding buffer, framer and
// shifter. The format word is taken by the shifter when a character moves in.
// Assumes: tick16 is a single-cycle enable at sixteen times the bit rate.
module sertx_dbuf
    import sertx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int LEN_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick16,
    input  logic                               load_n,
    input  logic [MIN_LEN + (1 << LEN_W) - 2:0] din,
    input  logic [LEN_W-1:0]                   len_code,
    input  logic                               par_off,
    input  logic                               par_even,
    input  logic                               stop_long,
    output logic                               txd,
    output logic                               hold_empty,
    output logic                               shift_empty
);
    localparam int DATA_W = MIN_LEN + (1 << LEN_W) - 1;
    localparam int CNT_W  = $clog2(DATA_W + 2);
    localparam int STW    = $clog2(2 * OVS + 1);

    tx_fmt_t           fmt;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              xfer;
    logic              ready;
    logic              idle;
    logic [DATA_W:0]   payload;
    logic [CNT_W-1:0]  nbits;
    logic [STW-1:0]    stop_ticks;

    assign fmt.len_code  = len_code;
    assign fmt.par_off   = par_off;
    assign fmt.par_even  = par_even;
    assign fmt.stop_long = stop_long;

    sertx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .load_n    (load_n),
        .din       (din),
        .ready_i   (ready),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .xfer_o    (xfer)
    );

    sertx_framer #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W), .STW(STW)) u_frame (
        .data       (hold_data),
        .fmt        (fmt),
        .payload    (payload),
        .nbits      (nbits),
        .stop_ticks (stop_ticks)
    );

    sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W), .STW(STW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .xfer       (xfer),
        .payload    (payload),
        .nbits      (nbits),
        .stop_ticks (stop_ticks),
        .txd        (txd),
        .idle       (idle),
        .ready      (ready)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = idle;

    // R2
    strobe_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_n) && hold_empty) |=> !hold_empty);

    // R3
    prompt_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && ready && tick16) |=> (!shift_empty && !txd));
endmodule

// File: tb/sertx_dbuf_tb_top.sv
// Bench for the double-buffered serial transmitter: a table of formats and
// characters walked by one loop, then directed corner cases.
module sertx_dbuf_tb_top;
    localparam int CLK_PERIOD = 10;

    // {data, len_code, par_off, par_even, stop_long}
    localparam logic [12:0] VEC [0:7] = '{
        {8'hA5, 2'd3, 1'b0, 1'b1, 1'b0},
        {8'hA5, 2'd3, 1'b0, 1'b0, 1'b1},
        {8'hF3, 2'd0, 1'b0, 1'b1, 1'b1},
        {8'h3C, 2'd1, 1'b1, 1'b0, 1'b0},
        {8'h55, 2'd2, 1'b0, 1'b0, 1'b1},
        {8'h00, 2'd3, 1'b0, 1'b0, 1'b0},
        {8'hE6, 2'd0, 1'b1, 1'b1, 1'b1},
        {8'h81, 2'd1, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [1:0] len_code = 2'd0;
    logic       par_off = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_long = 1'b0;
    logic       txd;
    logic       hold_empty;
    logic       shift_empty;

    int n_checks = 0;
    int n_err = 0;
    int tick_cnt = 0;

    sertx_dbuf dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .load_n      (load_n),
        .din         (din),
        .len_code    (len_code),
        .par_off     (par_off),
        .par_even    (par_even),
        .stop_long   (stop_long),
        .txd         (txd),
        .hold_empty  (hold_empty),
        .shift_empty (shift_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    always_ff @(posedge clk) begin
        if (tick16) tick_cnt <= tick_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int t);
        while (tick_cnt < t) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk);
        din = d;
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] lc, input logic po, input logic pe, input logic sl);
        len_code = lc;
        par_off = po;
        par_even = pe;
        stop_long = sl;
    endtask

    task automatic wait_start(output int t0);
        int guard = 0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk("R3 start bit seen", int'(txd), 0);
        t0 = tick_cnt;
    endtask

    task automatic check_frame(input int t0, input logic [7:0] d, input logic [1:0] lc,
                               input logic po, input logic pe, input logic sl,
                               output int t_end);
        int n;
        int m;
        int s;
        logic [7:0] dm;
        logic par;
        n = 5 + int'(lc);
        dm = '0;
        for (int k = 0; k < 8; k++) if (k < n) dm[k] = d[k];
        par = pe ? ^dm : ~^dm;
        m = 1 + n + (po ? 0 : 1);
        s = sl ? ((n == 5) ? 24 : 32) : 16;
        wait_tick(t0 + 8);
        chk("R5 start bit low", int'(txd), 0);
        wait_tick(t0 + 15);
        chk("R4 start bit lasts 16 ticks", int'(txd), 0);
        for (int k = 0; k < n; k++) begin
            wait_tick(t0 + 16 * (k + 1) + 8);
            chk($sformatf("R6 data bit %0d", k), int'(txd), int'(dm[k]));
        end
        if (!po) begin
            wait_tick(t0 + 16 * (n + 1) + 8);
            chk("R7 parity bit", int'(txd), int'(par));
        end
        wait_tick(t0 + 16 * m + 8);
        chk("R5 stop level", int'(txd), 1);
        wait_tick(t0 + 16 * m + s - 1);
        chk("R8 stop still high at last tick", int'(txd), 1);
        chk("R8 frame busy through stop", int'(shift_empty), 0);
        t_end = t0 + 16 * m + s;
    endtask

    initial begin
        int t0;
        int tr;
        int te;
        int te2;
        logic [7:0] d;
        logic [1:0] lc;
        logic po;
        logic pe;
        logic sl;

        repeat (4) @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset hold_empty", int'(hold_empty), 1);
        chk("R1 reset shift_empty", int'(shift_empty), 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // Table walk: each vector is one character in one format.
        for (int i = 0; i < 8; i++) begin
            {d, lc, po, pe, sl} = VEC[i];
            set_fmt(lc, po, pe, sl);
            strobe(d);
            tr = tick_cnt;
            chk("R2 strobe rise clears hold_empty", int'(hold_empty), 0);
            din = ~d;
            wait_start(t0);
            chk("R3 transfer on next tick", t0, tr + 1);
            chk("R3 hold_empty back high", int'(hold_empty), 1);
            chk("R3 shift_empty low", int'(shift_empty), 0);
            check_frame(t0, d, lc, po, pe, sl, te);
            wait_tick(te);
            chk("R11 shift_empty at stop end", int'(shift_empty), 1);
            chk("R11 line idle high", int'(txd), 1);
            repeat (6) @(negedge clk);
            chk("R11 line stays high", int'(txd), 1);
        end

        // R10: format changes during a frame do not touch it.
        set_fmt(2'd3, 1'b0, 1'b1, 1'b0);
        strobe(8'h5A);
        wait_start(t0);
        set_fmt(2'd0, 1'b1, 1'b0, 1'b1);
        check_frame(t0, 8'h5A, 2'd3, 1'b0, 1'b1, 1'b0, te);
        wait_tick(te);
        chk("R10 stop length from captured format", int'(shift_empty), 1);

        // R9: second character queued during a frame goes out end to end.
        set_fmt(2'd2, 1'b0, 1'b0, 1'b1);
        strobe(8'h31);
        wait_start(t0);
        fork
            check_frame(t0, 8'h31, 2'd2, 1'b0, 1'b0, 1'b1, te);
            begin
                wait_tick(t0 + 40);
                strobe(8'h4E);
                chk("R9 queued char holds buffer", int'(hold_empty), 0);
            end
        join
        chk("R9 buffer still full at last stop tick", int'(hold_empty), 0);
        wait_tick(te);
        chk("R9 next start bit with no gap", int'(txd), 0);
        chk("R9 buffer freed at handover", int'(hold_empty), 1);
        chk("R9 shifter stays busy", int'(shift_empty), 0);
        check_frame(te, 8'h4E, 2'd2, 1'b0, 1'b0, 1'b1, te2);
        wait_tick(te2);
        chk("R11 idle after queued frame", int'(shift_empty), 1);

        // R12: reset mid-frame drops the frame and the queued character.
        set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
        strobe(8'hC3);
        wait_start(t0);
        wait_tick(t0 + 20);
        strobe(8'h11);
        wait_tick(t0 + 40);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset txd high", int'(txd), 1);
        chk("R12 reset hold_empty", int'(hold_empty), 1);
        chk("R12 reset shift_empty", int'(shift_empty), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk("R12 queued char discarded, line high", int'(txd), 1);
        chk("R12 shifter stays idle", int'(shift_empty), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule